// File: doc/BRIEF.md
# 4B5B Transmit Framing Encoder

This block turns the nibble-wide transmit stream of a media-independent interface into 5-bit code groups, one per clock. The stream has a 4-bit data bus, an enable that marks the frame and an error flag. Between frames the output carries the idle code without a break. When a frame opens, the encoder drops the first two nibbles, which are preamble, and sends the start delimiter pair J then K in their place. It maps every later nibble through the fixed 16-entry data code table. When enable falls, it appends the end delimiter pair T then R and then goes back to idle.

The output register adds one cycle of latency. The symbol appears one clock after the nibble that produced it was sampled. The output side is a valid strobe and carries no ready signal. After reset the strobe stays high on every cycle, and the consumer must take a symbol on each clock, so there is no back-pressure. The input side has no handshake either: a nibble is taken on every clock edge. Serialization, scrambling and line coding belong to the stages that follow this block.

Top module: `tx4b5b_framer`

## Requirements
- R1: While reset is held, the symbol output is 11111 and the valid strobe is 0. From the first clock edge after reset is released, valid is 1 on every cycle, and the downstream stage must accept one symbol per clock.
- R2: While no frame is in progress and enable is low, the output is the idle code 11111, whatever the data and error inputs hold.
- R3: The edge that samples a rising enable produces J (11000), and the next edge produces K (10001). The data and error inputs on those two nibbles have no effect on the output.
- R4: From the third nibble of a frame on, a nibble with the error input low is output one cycle later as its data code. The codes for nibbles 0 to F, written bit 4 down to bit 0, are 11110 01001 10100 10101 01010 01011 01110 01111 10010 10011 10110 10111 11010 11011 11100 11101.
- R5: From the third nibble of a frame on, a nibble sampled with the error input high is output as the halt code 00100 instead of its data code.
- R6: For a frame of two or more nibbles, the edge that samples enable low produces T (01101), and the next edge produces R (00111). For a one-nibble frame, K is still sent in full and is followed by T and then R.
- R7: After R the output returns to idle. If enable is high on the nibble sampled while R is being produced, that nibble is dropped, and a new frame starts with J on the following edge when enable is still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Frame enable, high for every nibble of a frame |
| tx_er | input | 1 | Error flag for the current nibble |
| tx_nib | input | 4 | Transmit nibble |
| sym_valid | output | 1 | Code group valid strobe |
| sym_out | output | 5 | Registered 5-bit code group, bit 4 first in the table order |

## Verification
The in-RTL assertions check the delimiter ordering on every cycle: J is always followed by K, T by R, and R by idle or J. They also check that idle persists while enable stays low, that a flagged data nibble becomes the halt code, and that valid stays high after reset. Only the bench scenarios can show that every nibble value maps to its correct code and that the two preamble nibbles are dropped. The same holds for the timing of the end delimiter after one-nibble and longer frames, and for the nibble lost when enable is raised again during R.

// File: rtl/tx4b5b_pkg.sv
package tx4b5b_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;

  typedef logic [SYM_W-1:0] sym_t;

  localparam sym_t SYM_IDLE = 5'b11111;
  localparam sym_t SYM_J    = 5'b11000;
  localparam sym_t SYM_K    = 5'b10001;
  localparam sym_t SYM_T    = 5'b01101;
  localparam sym_t SYM_R    = 5'b00111;
  localparam sym_t SYM_HALT = 5'b00100;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SECOND, PH_DATA, PH_TAIL_T, PH_TAIL_R
  } phase_e;

  typedef enum logic [2:0] {
    PICK_IDLE, PICK_J, PICK_K, PICK_DATA, PICK_T, PICK_R
  } pick_e;
endpackage

// File: rtl/tx4b5b_nibble_map.sv
module tx4b5b_nibble_map
  import tx4b5b_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output sym_t             code
);
  always_comb begin
    unique case (nib)
      4'h0: code = 5'b11110;
      4'h1: code = 5'b01001;
      4'h2: code = 5'b10100;
      4'h3: code = 5'b10101;
      4'h4: code = 5'b01010;
      4'h5: code = 5'b01011;
      4'h6: code = 5'b01110;
      4'h7: code = 5'b01111;
      4'h8: code = 5'b10010;
      4'h9: code = 5'b10011;
      4'hA: code = 5'b10110;
      4'hB: code = 5'b10111;
      4'hC: code = 5'b11010;
      4'hD: code = 5'b11011;
      4'hE: code = 5'b11100;
      default: code = 5'b11101;
    endcase
  end
endmodule

// File: rtl/tx4b5b_phase_ctl.sv
module tx4b5b_phase_ctl
  import tx4b5b_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tx_en,
  output pick_e pick
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    pick = PICK_IDLE;
    unique case (ph_q)
      PH_IDLE: begin
        if (tx_en) begin
          pick = PICK_J;
          ph_d = PH_SECOND;
        end
      end
      PH_SECOND: begin
        pick = PICK_K;
        ph_d = tx_en ? PH_DATA : PH_TAIL_T;
      end
      PH_DATA: begin
        if (tx_en) begin
          pick = PICK_DATA;
        end else begin
          pick = PICK_T;
          ph_d = PH_TAIL_R;
        end
      end
      PH_TAIL_T: begin
        pick = PICK_T;
        ph_d = PH_TAIL_R;
      end
      default: begin
        pick = PICK_R;
        ph_d = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  // R7: the end pair always hands back to the idle phase
  assert_tail_returns_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TAIL_R) |=> (ph_q == PH_IDLE));

  // R3: the start pair is never cut short
  assert_second_follows_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && tx_en) |=> (ph_q == PH_SECOND));
endmodule

// File: rtl/tx4b5b_framer.sv
module tx4b5b_framer
  import tx4b5b_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] tx_nib,
  output logic             sym_valid,
  output logic [SYM_W-1:0] sym_out
);
  pick_e pick;
  sym_t  data_code;
  sym_t  sym_d;
  sym_t  sym_q;
  logic  valid_q;

  tx4b5b_phase_ctl u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_en (tx_en),
    .pick  (pick)
  );

  tx4b5b_nibble_map u_map (
    .nib  (tx_nib),
    .code (data_code)
  );

  always_comb begin
    unique case (pick)
      PICK_J:    sym_d = SYM_J;
      PICK_K:    sym_d = SYM_K;
      PICK_DATA: sym_d = tx_er ? SYM_HALT : data_code;
      PICK_T:    sym_d = SYM_T;
      PICK_R:    sym_d = SYM_R;
      default:   sym_d = SYM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q   <= SYM_IDLE;
      valid_q <= 1'b0;
    end else begin
      sym_q   <= sym_d;
      valid_q <= 1'b1;
    end
  end

  assign sym_out   = sym_q;
  assign sym_valid = valid_q;

  assert_valid_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sym_valid);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_q == SYM_IDLE && !tx_en) |=> (sym_q == SYM_IDLE));

  assert_j_then_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_q == SYM_J) |=> (sym_q == SYM_K));

  assert_t_then_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_q == SYM_T) |=> (sym_q == SYM_R));

  assert_r_then_idle_or_j_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_q == SYM_R) |=> (sym_q == SYM_IDLE || sym_q == SYM_J));

  assert_flagged_nibble_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pick == PICK_DATA && tx_er) |=> (sym_q == SYM_HALT));
endmodule

// File: tb/tx4b5b_framer_test.sv
`timescale 1ns/1ps
module tx4b5b_framer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] tx_nib = 4'h0;
  logic       sym_valid;
  logic [4:0] sym_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [4:0] I_C = 5'b11111, J_C = 5'b11000, K_C = 5'b10001;
  localparam logic [4:0] T_C = 5'b01101, R_C = 5'b00111, H_C = 5'b00100;

  always #2.5 clk = ~clk;

  tx4b5b_framer uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
    .tx_nib(tx_nib), .sym_valid(sym_valid), .sym_out(sym_out)
  );

  function automatic logic [4:0] ref_code(input logic [3:0] n);
    case (n)
      4'h0: ref_code = 5'b11110; 4'h1: ref_code = 5'b01001;
      4'h2: ref_code = 5'b10100; 4'h3: ref_code = 5'b10101;
      4'h4: ref_code = 5'b01010; 4'h5: ref_code = 5'b01011;
      4'h6: ref_code = 5'b01110; 4'h7: ref_code = 5'b01111;
      4'h8: ref_code = 5'b10010; 4'h9: ref_code = 5'b10011;
      4'hA: ref_code = 5'b10110; 4'hB: ref_code = 5'b10111;
      4'hC: ref_code = 5'b11010; 4'hD: ref_code = 5'b11011;
      4'hE: ref_code = 5'b11100; default: ref_code = 5'b11101;
    endcase
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic er, input logic [3:0] d,
                      input string req, input logic [4:0] exp);
    tx_en = en; tx_er = er; tx_nib = d;
    @(posedge clk); #1;
    check(req, sym_out, exp);
    check({req, "_valid"}, {4'b0, sym_valid}, 5'd1);
  endtask

  // err_mode: 0 none, 1 every other data nibble, 2 on every nibble
  task automatic frame(input int len, input int seed, input int err_mode, input bit reopen);
    for (int i = 0; i < len; i++) begin
      logic [3:0] d = 4'((seed + i * 7) & 15);
      logic er = (err_mode == 2) || (err_mode == 1 && i[0]);
      if (i == 0)      step(1'b1, er, d, "R3_J", J_C);
      else if (i == 1) step(1'b1, er, d, "R3_K", K_C);
      else if (er)     step(1'b1, er, d, "R5_halt", H_C);
      else             step(1'b1, er, d, "R4_code", ref_code(d));
    end
    if (len == 1) step(1'b0, 1'b1, 4'h3, "R6_short_K", K_C);
    step(1'b0, 1'b1, 4'h5, "R6_T", T_C);
    if (reopen) step(1'b1, 1'b0, 4'h9, "R7_R_drop", R_C);
    else        step(1'b0, 1'b0, 4'h9, "R6_R", R_C);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1_reset_sym", sym_out, I_C);
    check("R1_reset_valid", {4'b0, sym_valid}, 5'd0);
    rst_n = 1'b1;
    // R2: idle with moving data and error while enable low
    for (int i = 0; i < 16; i++) step(1'b0, i[0], 4'(i), "R2_idle", I_C);
    // R4: every nibble value after the preamble
    frame(20, 0, 0, 1'b0);
    step(1'b0, 1'b0, 4'h0, "R7_idle_after_R", I_C);
    // R4 sweep of data values with different strides
    for (int s = 1; s < 16; s += 3) begin
      frame(18, s, 0, 1'b0);
      step(1'b0, 1'b1, 4'hF, "R2_gap", I_C);
    end
    // R5: alternate error, R3: error on preamble ignored
    frame(12, 5, 1, 1'b0);
    frame(6, 2, 2, 1'b0);
    // R6: short frames
    frame(1, 4, 0, 1'b0);
    step(1'b0, 1'b0, 4'h0, "R2_gap", I_C);
    frame(2, 9, 0, 1'b0);
    frame(3, 11, 0, 1'b0);
    // R7: enable raised again during R; that nibble is dropped
    frame(5, 3, 0, 1'b1);
    frame(4, 8, 0, 1'b1);
    frame(1, 6, 0, 1'b1);
    frame(7, 1, 0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4'(i), "R2_final_idle", I_C);
    // R1: reset asserted mid-frame
    step(1'b1, 1'b0, 4'h1, "R3_J", J_C);
    #1 rst_n = 1'b0; #1;
    check("R1_midreset_sym", sym_out, I_C);
    check("R1_midreset_valid", {4'b0, sym_valid}, 5'd0);
    tx_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0, 4'h0, "R1_after_reset", I_C);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule